// File: doc/BRIEF.md
# Programmable Clock Divider with Whole-Cycle Phase Slip

This block derives an encode timing signal from a fast input clock. A 3-bit ratio field picks a division factor N equal to the field value plus one, so N runs from 1 to 8. A 3-bit phase field moves the divided waveform later by a whole number of input cycles. The reference point for that move is the start of a restart. Both fields are latched only when the resynchronization strobe is seen. The counter then restarts from a known point, so a half-written field never reaches the output.

The block drives two outputs, both in the input clock domain. `enc_en_o` is a one-cycle encode pulse. `div_o` is the divided clock as a level. When N is 1, both outputs stay high in every running cycle, so the clock is passed on undivided.

The control is a three-state machine:
- `ST_HOLD` is entered on reset. Both fields are zero in this state. It moves unconditionally to `ST_RUN`.
- `ST_RUN` counts. When it sees the strobe, the fields are captured and it moves to `ST_LOAD`. Without the strobe it stays in `ST_RUN`.
- `ST_LOAD` lasts one cycle, during which the counter is preset. It moves unconditionally to `ST_RUN`.

Both outputs are low in `ST_HOLD` and in `ST_LOAD`.

Top module: `clkdiv_phase`

## Requirements
- R1: With ratio field r, N = r + 1, and `enc_en_o` pulses for exactly one cycle every N cycles while running.
- R2: With ratio field 0, `enc_en_o` and `div_o` are both high in every running cycle.
- R3: Running cycles are counted as k = 0, 1, 2, … from the first `ST_RUN` cycle after a restart. `enc_en_o` is high exactly when k mod N equals the effective phase.
- R4: The effective phase is the phase field modulo N. A phase field of N or more therefore wraps.
- R5: For N ≥ 2, `div_o` is high for floor(N/2) cycles starting at each encode pulse, and low for the rest of the period. Even N gives 50 % duty. For odd N, the high part is one cycle shorter than the low part.
- R6: While `rst_i` is high, both outputs are low and both fields reset to zero. The first cycle after reset release is running cycle k = 0 with N = 1 and phase 0, whatever the field inputs are.
- R7: A change on `ratio_i` or `phase_i` without a strobe has no effect on the outputs.
- R8: A strobe seen in a running cycle makes the next cycle a `ST_LOAD` cycle with both outputs low. The cycle after that is k = 0 under the new fields. This also holds when the strobe coincides with an encode pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| resync_i | input | 1 | Strobe that captures the fields and restarts the count |
| ratio_i | input | 3 | Division factor minus one |
| phase_i | input | 3 | Phase slip in whole input cycles |
| enc_en_o | output | 1 | One-cycle encode pulse |
| div_o | output | 1 | Divided clock as a level |

## Verification
A resynchronization strobe can arrive in the very cycle that carries an encode pulse, so the restart and the count wrap compete for the same edge. The bench provokes this by waiting for a high `enc_en_o` and raising the strobe in that same cycle with new fields. It then expects one low `ST_LOAD` cycle, followed by a pattern counted from k = 0 under the new fields. The restart must win with no stray pulse. Every sweep case also scrambles the field inputs right after capture, so a field that leaks through would show up as a wrong period or a wrong edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } div_state_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          resync_i,
    input  logic [RW-1:0] ratio_i,
    input  logic [RW-1:0] phase_i,
    output div_state_t    state_o,
    output logic [RW-1:0] ratio_q_o,
    output logic [RW-1:0] phase_q_o
);
    localparam int NW = RW + 1;

    div_state_t    state_q, state_d;
    logic [NW-1:0] n_in, ph_ext, ph_mod;
    logic          capture;

    assign n_in    = NW'(ratio_i) + NW'(1);
    assign ph_ext  = NW'(phase_i);
    assign ph_mod  = ph_ext % n_in;
    assign capture = (state_q == ST_RUN) && resync_i;

    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  state_d = resync_i ? ST_LOAD : ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_HOLD;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ratio_q_o <= '0;
            phase_q_o <= '0;
        end else if (capture) begin
            ratio_q_o <= ratio_i;
            phase_q_o <= ph_mod[RW-1:0];
        end
    end

    assign state_o = state_q;

    assert_hold_to_run_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HOLD) |=> (state_q == ST_RUN));
    assert_strobe_load_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && resync_i) |=> (state_q == ST_LOAD));
    assert_fields_stable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_RUN || !resync_i) |=> ($stable(ratio_q_o) && $stable(phase_q_o)));
    assert_phase_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_q_o <= ratio_q_o);
endmodule

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt
    import clkdiv_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  div_state_t    state_i,
    input  logic [RW-1:0] ratio_q_i,
    input  logic [RW-1:0] phase_q_i,
    output logic [RW-1:0] pos_o
);
    logic [RW-1:0] start;

    // Preset so that position zero falls on run cycle k = phase.
    assign start = (phase_q_i == '0) ? '0 : RW'(ratio_q_i - phase_q_i + RW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i)                   pos_o <= '0;
        else if (state_i != ST_RUN)  pos_o <= start;
        else if (pos_o == ratio_q_i) pos_o <= '0;
        else                         pos_o <= pos_o + RW'(1);
    end

    assert_pos_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_o <= ratio_q_i);
    assert_pos_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_RUN && pos_o != ratio_q_i) |=>
            (state_i != ST_RUN || pos_o == $past(pos_o) + RW'(1)));
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
    import clkdiv_pkg::*;
#(
    parameter int RW = 3
) (
    input  div_state_t    state_i,
    input  logic [RW-1:0] ratio_q_i,
    input  logic [RW-1:0] pos_i,
    output logic          enc_en_o,
    output logic          div_o
);
    localparam int NW = RW + 1;

    logic [NW-1:0] half;

    assign half = (NW'(ratio_q_i) + NW'(1)) >> 1;

    always_comb begin
        unique case (state_i)
            ST_RUN: begin
                enc_en_o = (pos_i == '0);
                div_o    = (ratio_q_i == '0) ? 1'b1 : (NW'(pos_i) < half);
            end
            default: begin
                enc_en_o = 1'b0;
                div_o    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          resync_i,
    input  logic [RW-1:0] ratio_i,
    input  logic [RW-1:0] phase_i,
    output logic          enc_en_o,
    output logic          div_o
);
    div_state_t    state;
    logic [RW-1:0] ratio_q, phase_q, pos;

    clkdiv_ctrl #(.RW(RW)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .resync_i  (resync_i),
        .ratio_i   (ratio_i),
        .phase_i   (phase_i),
        .state_o   (state),
        .ratio_q_o (ratio_q),
        .phase_q_o (phase_q)
    );

    clkdiv_cnt #(.RW(RW)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .state_i   (state),
        .ratio_q_i (ratio_q),
        .phase_q_i (phase_q),
        .pos_o     (pos)
    );

    clkdiv_wave #(.RW(RW)) u_wave (
        .state_i   (state),
        .ratio_q_i (ratio_q),
        .pos_i     (pos),
        .enc_en_o  (enc_en_o),
        .div_o     (div_o)
    );

    assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (enc_en_o && ratio_q != '0 && !resync_i) |=> !enc_en_o);
    assert_enc_in_high_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (enc_en_o && ratio_q != '0) |-> div_o);
    assert_reset_low_R6: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!enc_en_o && !div_o));
    assert_bypass_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_RUN && ratio_q == '0) |-> (enc_en_o && div_o));
endmodule

// File: tb/clkdiv_phase_bench.sv
module clkdiv_phase_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       resync = 1'b0;
    logic [2:0] ratio = 3'd5;
    logic [2:0] phase = 3'd3;
    logic       enc_en, div;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    clkdiv_phase u_clkdiv_phase (
        .clk_i    (clk),
        .rst_i    (rst),
        .resync_i (resync),
        .ratio_i  (ratio),
        .phase_i  (phase),
        .enc_en_o (enc_en),
        .div_o    (div)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_enc(input int n, input int pe, input int k);
        return (k % n) == pe;
    endfunction

    function automatic logic exp_div(input int n, input int pe, input int k);
        if (n == 1) return 1'b1;
        return ((k + n - pe) % n) < (n / 2);
    endfunction

    // Called at a negedge while running; strobes and checks 3N cycles after the restart.
    task automatic run_case(input int r, input int p, input string tag);
        int n  = r + 1;
        int pe = p % n;
        string etag = (r == 0) ? "R2" : ((p >= n) ? "R4" : "R3");
        string dtag = (r == 0) ? "R2" : "R5";
        ratio  = 3'(r);
        phase  = 3'(p);
        resync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resync = 1'b0;
        check(enc_en, 1'b0, tag, "load cycle enc");
        check(div, 1'b0, tag, "load cycle div");
        ratio = ~3'(r);   // R7: scrambled inputs must not matter
        phase = ~3'(p);
        for (int k = 0; k < 3 * n; k++) begin
            @(negedge clk);
            check(enc_en, exp_enc(n, pe, k), etag, $sformatf("enc N=%0d ph=%0d k=%0d R1 R7", n, p, k));
            check(div, exp_div(n, pe, k), dtag, $sformatf("div N=%0d ph=%0d k=%0d R7", n, p, k));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(enc_en, 1'b0, "R6", "enc in reset");
        check(div, 1'b0, "R6", "div in reset");
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(enc_en, 1'b1, "R6", "enc after reset, fields zero");
            check(div, 1'b1, "R6", "div after reset, fields zero");
        end
        for (int r = 0; r < 8; r++)
            for (int p = 0; p < 8; p++)
                run_case(r, p, "R8");
        // R8: strobe coinciding with an encode pulse
        run_case(3, 2, "R8");
        while (enc_en !== 1'b1) @(negedge clk);
        run_case(2, 1, "R8");
        while (enc_en !== 1'b1) @(negedge clk);
        run_case(6, 7, "R8");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule